// File: doc/BRIEF.md
# Local SRAM Window Decoder

This block holds the configuration word for a small on-chip SRAM and decides, for every bus access, whether the access falls inside the SRAM's 4 KB window. The configuration word carries a base address, a write-protect flag, a valid flag and five plain tag bits. Privileged CPU software sets it by writing control-register index 0xC04. A debug port can both read and write it. The CPU cannot read it back.

Each bus request is compared against the programmed window. On a hit, the block raises a registered select for the SRAM array, together with the offset inside the window and the privilege level of the access. A write enable goes to the array only when the window is not write-protected. A write that hits a protected window becomes an access error and is not silently dropped. A CPU write attempted in user mode leaves the register unchanged and raises a one-cycle privilege-violation pulse.

Top module: `sram_window_decoder`

## Requirements
- R1: After reset the valid flag (bit 0) reads 0 and no bus access selects the SRAM, whatever the other configuration bits hold; any access while valid is 0 also produces no select.
- R2: A request hits when valid is 1 and address bits 31:12 equal configuration bits 31:12. A hit covers every address from base to base+0xFFF and no address outside that range, including the top window ending at 0xFFFFFFFF.
- R3: `sram_sel`, `sram_we`, `sram_off`, `sram_super` and `acc_err` are registered and reflect the request presented one clock earlier; they are all low in the cycle after a clock with no request.
- R4: With write-protect (bit 8) at 0, a write hit raises `sram_we`. With it at 1, a read hit still selects, and a write hit raises `acc_err` and `sram_sel` with `sram_we` low. A miss never raises `acc_err`.
- R5: A CPU write with `cpu_super`=1 and `cpu_idx`=0xC04 loads the register; a CPU write to any other index leaves it unchanged.
- R6: A CPU write to index 0xC04 with `cpu_super`=0 leaves the register unchanged and sets `priv_err` for exactly the following cycle.
- R7: `dbg_rdata` shows the stored word; a debug write loads the register and takes precedence over a CPU write in the same cycle.
- R8: Bits 11:9 and 7:6 always read 0 whatever was written. Bits 5:1 are stored and read back, but they have no effect on hit, protection or error decoding.
- R9: On a hit, `sram_off` carries address bits 11:0 and `sram_super` carries the access's supervisor flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | CPU control-register write strobe |
| cpu_idx | input | 12 | CPU control-register index |
| cpu_super | input | 1 | CPU is in supervisor mode |
| cpu_wdata | input | 32 | CPU write data |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Stored configuration word |
| bus_req | input | 1 | Bus access request |
| bus_addr | input | 32 | Bus access address |
| bus_wr | input | 1 | Access is a write |
| bus_super | input | 1 | Access is made in supervisor mode |
| sram_sel | output | 1 | SRAM selected (registered) |
| sram_we | output | 1 | SRAM write enable (registered) |
| sram_off | output | 12 | Offset within window (registered) |
| sram_super | output | 1 | Privilege of the selected access (registered) |
| acc_err | output | 1 | Write to protected window (registered) |
| priv_err | output | 1 | User-mode CPU write attempt (registered pulse) |

## Verification
The bench builds the block with its default parameters: a 12-bit window, a 12-bit register index and index 0xC04. With these values the full 32-bit address space can be reached by hand, so the bench checks the last byte of the window at the very top of the space and the addresses one below and one past a window. It also tests the index values just next to 0xC04, and tag-bit patterns that would look like a valid or protected flag if the decode were shifted.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int CFG_W   = 32;
  localparam int VLD_POS = 0;
  localparam int WP_POS  = 8;
  localparam int TAG_HI  = 5;

  // Bits that hold storage; everything else reads back as zero.
  function automatic logic [CFG_W-1:0] keep_mask(input int win_lg2);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < CFG_W; i++) begin
      if (i >= win_lg2 || i == WP_POS || i <= TAG_HI) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/srw_rst_sync.sv
module srw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/srw_cfg_reg.sv
module srw_cfg_reg
  import srw_pkg::*;
#(
  parameter int unsigned WIN_LG2 = 12,
  parameter int unsigned IDX_W   = 12,
  parameter logic [IDX_W-1:0] CFG_IDX = 12'hC04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             cpu_super,
  input  logic [CFG_W-1:0] cpu_wdata,
  input  logic             dbg_we,
  input  logic [CFG_W-1:0] dbg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             priv_err
);
  localparam logic [CFG_W-1:0] KEEP = keep_mask(WIN_LG2);

  logic             cpu_hit;
  logic             cfg_en;
  logic [CFG_W-1:0] cfg_d;
  logic             priv_d;
  logic             vld_q;
  logic [CFG_W-1:1] rest_q;

  // Next-state logic: debug has priority over the CPU.
  always_comb begin
    cpu_hit = cpu_we && (cpu_idx == CFG_IDX);
    cfg_en  = dbg_we || (cpu_hit && cpu_super);
    cfg_d   = (dbg_we ? dbg_wdata : cpu_wdata) & KEEP;
    priv_d  = cpu_hit && !cpu_super;
  end

  // Only the valid flag has a defined reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      priv_err <= 1'b0;
    end else begin
      priv_err <= priv_d;
      if (cfg_en) vld_q <= cfg_d[VLD_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_en) rest_q <= cfg_d[CFG_W-1:1];
  end

  assign cfg_q = {rest_q, vld_q};

  AST_USER_WR_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_idx == CFG_IDX && !cpu_super && !dbg_we) |=> $stable(cfg_q[VLD_POS])); // R6
  AST_PRIV_NEEDS_ATTEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |-> $past(cpu_we && !cpu_super)); // R6
  AST_DBG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> (cfg_q[VLD_POS] == $past(dbg_wdata[VLD_POS]))); // R7
endmodule

// File: rtl/srw_match.sv
module srw_match
  import srw_pkg::*;
#(
  parameter int unsigned WIN_LG2 = 12,
  localparam int unsigned BASE_W = CFG_W - WIN_LG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic               cfg_vld,
  input  logic               cfg_wp,
  input  logic               bus_req,
  input  logic [CFG_W-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic               bus_super,
  output logic               sram_sel,
  output logic               sram_we,
  output logic [WIN_LG2-1:0] sram_off,
  output logic               sram_super,
  output logic               acc_err
);
  logic               hit;
  logic               sel_d, we_d, sup_d, err_d;
  logic [WIN_LG2-1:0] off_d;

  always_comb begin
    hit   = bus_req && cfg_vld && (bus_addr[CFG_W-1:WIN_LG2] == cfg_base);
    sel_d = hit;
    we_d  = hit && bus_wr && !cfg_wp;
    err_d = hit && bus_wr && cfg_wp;
    sup_d = hit && bus_super;
    off_d = hit ? bus_addr[WIN_LG2-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_sel   <= 1'b0;
      sram_we    <= 1'b0;
      acc_err    <= 1'b0;
      sram_super <= 1'b0;
      sram_off   <= '0;
    end else begin
      sram_sel   <= sel_d;
      sram_we    <= we_d;
      acc_err    <= err_d;
      sram_super <= sup_d;
      sram_off   <= off_d;
    end
  end

  AST_INVALID_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cfg_vld) |=> !sram_sel); // R1
  AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr[CFG_W-1:WIN_LG2] != cfg_base) |=> (!sram_sel && !acc_err)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> (!sram_sel && !sram_we && !acc_err)); // R3
  AST_WP_BLOCKS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && cfg_wp) |=> !sram_we); // R4
  AST_ERR_IMPLIES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (sram_sel && !sram_we)); // R4
endmodule

// File: rtl/sram_window_decoder.sv
module sram_window_decoder
  import srw_pkg::*;
#(
  parameter int unsigned WIN_LG2 = 12,
  parameter int unsigned IDX_W   = 12,
  parameter logic [IDX_W-1:0] CFG_IDX = 12'hC04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [IDX_W-1:0]   cpu_idx,
  input  logic               cpu_super,
  input  logic [31:0]        cpu_wdata,
  input  logic               dbg_we,
  input  logic [31:0]        dbg_wdata,
  output logic [31:0]        dbg_rdata,
  input  logic               bus_req,
  input  logic [31:0]        bus_addr,
  input  logic               bus_wr,
  input  logic               bus_super,
  output logic               sram_sel,
  output logic               sram_we,
  output logic [WIN_LG2-1:0] sram_off,
  output logic               sram_super,
  output logic               acc_err,
  output logic               priv_err
);
  localparam int unsigned BASE_W = CFG_W - WIN_LG2;

  logic             rst_n_s;
  logic [CFG_W-1:0] cfg_q;

  srw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  srw_cfg_reg #(
    .WIN_LG2 (WIN_LG2),
    .IDX_W   (IDX_W),
    .CFG_IDX (CFG_IDX)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cpu_we    (cpu_we),
    .cpu_idx   (cpu_idx),
    .cpu_super (cpu_super),
    .cpu_wdata (cpu_wdata),
    .dbg_we    (dbg_we),
    .dbg_wdata (dbg_wdata),
    .cfg_q     (cfg_q),
    .priv_err  (priv_err)
  );

  srw_match #(
    .WIN_LG2 (WIN_LG2)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_base   (cfg_q[CFG_W-1:WIN_LG2]),
    .cfg_vld    (cfg_q[VLD_POS]),
    .cfg_wp     (cfg_q[WP_POS]),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_super  (bus_super),
    .sram_sel   (sram_sel),
    .sram_we    (sram_we),
    .sram_off   (sram_off),
    .sram_super (sram_super),
    .acc_err    (acc_err)
  );

  assign dbg_rdata = cfg_q;

  initial begin
    assert (BASE_W > 0 && WIN_LG2 > WP_POS); // R2
  end
endmodule

// File: tb/sram_window_decoder_tb.sv
`timescale 1ns/1ps
module sram_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we, cpu_super, dbg_we, bus_req, bus_wr, bus_super;
  logic [11:0] cpu_idx;
  logic [31:0] cpu_wdata, dbg_wdata, dbg_rdata, bus_addr;
  logic        sram_sel, sram_we, sram_super, acc_err, priv_err;
  logic [11:0] sram_off;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sram_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_super(cpu_super), .cpu_wdata(cpu_wdata),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_super(bus_super),
    .sram_sel(sram_sel), .sram_we(sram_we), .sram_off(sram_off),
    .sram_super(sram_super), .acc_err(acc_err), .priv_err(priv_err)
  );

  // {cfg, addr, wr, super, exp_sel, exp_we, exp_err}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {32'h2000_5001, 32'h2000_5000, 5'b00100},  // R2 base, read
    {32'h2000_5001, 32'h2000_5FFC, 5'b11110},  // R2 R4 top of window, write
    {32'h2000_5001, 32'h2000_4FFF, 5'b00000},  // R2 one below
    {32'h2000_5001, 32'h2000_6000, 5'b10000},  // R2 one past
    {32'h2000_5101, 32'h2000_5010, 5'b01100},  // R4 protected read
    {32'h2000_5101, 32'h2000_5010, 5'b10101},  // R4 protected write
    {32'h2000_5101, 32'h2000_6000, 5'b10000},  // R4 miss, no error
    {32'h2000_5000, 32'h2000_5000, 5'b10000},  // R1 valid clear
    {32'hFFFF_F001, 32'hFFFF_FFFF, 5'b11110},  // R2 top of space
    {32'hFFFF_F001, 32'h0000_0FFF, 5'b00000},  // R2 wrap miss
    {32'h0000_103E, 32'h0000_1000, 5'b00000},  // R8 tags do not validate
    {32'h0000_103F, 32'h0000_1000, 5'b10110}   // R8 tags do not protect
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_we = 0; cpu_idx = 12'hC04; cpu_super = 0; cpu_wdata = 0;
    dbg_we = 0; dbg_wdata = 0;
    bus_req = 0; bus_addr = 0; bus_wr = 0; bus_super = 0;
  endtask

  task automatic dbg_write(input logic [31:0] d);
    @(negedge clk); dbg_we = 1; dbg_wdata = d;
    @(negedge clk); dbg_we = 0;
  endtask

  task automatic cpu_write(input logic [11:0] idx, input logic sup, input logic [31:0] d);
    @(negedge clk); cpu_we = 1; cpu_idx = idx; cpu_super = sup; cpu_wdata = d;
    @(negedge clk); cpu_we = 0; cpu_super = 0;
  endtask

  // Presents one request; returns at the negedge where its result is visible.
  task automatic access(input logic [31:0] a, input logic wr, input logic sup);
    @(negedge clk); bus_req = 1; bus_addr = a; bus_wr = wr; bus_super = sup;
    @(negedge clk); bus_req = 0;
  endtask

  task automatic run_vec(input logic [68:0] v);
    logic es;
    dbg_write(v[68:37]);
    access(v[36:5], v[4], v[3]);
    es = v[2];
    chk("R2 sram_sel", {31'b0, sram_sel}, {31'b0, es});
    chk("R4 sram_we", {31'b0, sram_we}, {31'b0, v[1]});
    chk("R4 acc_err", {31'b0, acc_err}, {31'b0, v[0]});
    chk("R9 sram_super", {31'b0, sram_super}, {31'b0, es & v[3]});
    if (es) chk("R9 sram_off", {20'b0, sram_off}, {20'b0, v[16:5]});
    @(negedge clk);
    chk("R3 idle sel", {29'b0, sram_sel, sram_we, acc_err}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 valid after reset", {31'b0, dbg_rdata[0]}, 32'h0);
    chk("R1 priv_err after reset", {31'b0, priv_err}, 32'h0);
    access(32'h0000_0000, 1'b1, 1'b1);
    chk("R1 no select after reset", {30'b0, sram_sel, acc_err}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R5 supervisor CPU write
    cpu_write(12'hC04, 1'b1, 32'h4000_0001);
    chk("R5 cpu write loads", dbg_rdata, 32'h4000_0001);
    access(32'h4000_0123, 1'b0, 1'b1);
    chk("R5 window after cpu write", {20'b0, sram_off}, 32'h123);
    cpu_write(12'hC05, 1'b1, 32'h5000_0001);
    chk("R5 other index ignored", dbg_rdata, 32'h4000_0001);
    cpu_write(12'hC03, 1'b1, 32'h5000_0001);
    chk("R5 other index ignored", dbg_rdata, 32'h4000_0001);

    // R6 user-mode attempt
    @(negedge clk); cpu_we = 1; cpu_idx = 12'hC04; cpu_super = 0; cpu_wdata = 32'h0;
    @(negedge clk); cpu_we = 0;
    chk("R6 priv_err pulse", {31'b0, priv_err}, 32'h1);
    chk("R6 register kept", dbg_rdata, 32'h4000_0001);
    @(negedge clk);
    chk("R6 priv_err one cycle", {31'b0, priv_err}, 32'h0);

    // R7 debug beats CPU in the same cycle
    @(negedge clk);
    dbg_we = 1; dbg_wdata = 32'h6000_0001;
    cpu_we = 1; cpu_idx = 12'hC04; cpu_super = 1; cpu_wdata = 32'h7000_0001;
    @(negedge clk); dbg_we = 0; cpu_we = 0; cpu_super = 0;
    chk("R7 debug priority", dbg_rdata, 32'h6000_0001);

    // R8 reserved bits read zero
    dbg_write(32'hFFFF_FFFF);
    chk("R8 reserved cleared", dbg_rdata, 32'hFFFF_F13F);
    dbg_write(32'h1234_503E);
    chk("R8 tag bits stored", dbg_rdata, 32'h1234_503E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule